// File: doc/BRIEF.md
# Serial Slave Port with Interrupt on Data Out

This block is the serial front end of a peripheral that sits on a fast system clock. A host talks to it over four wires: an active-low select, a serial clock, data in and data out. The block samples all three incoming pins with the system clock and detects edges on the sampled copies. One transaction moves exactly one 32-bit word in each direction. The incoming word is taken most significant bit first on rising serial clock edges. The outgoing word is a parallel value loaded when the transaction starts. When a complete word has arrived and select returns high, the received word is presented with a one-cycle strobe.

The data-out pin is always driven. While select is high, or while a select-low period has been rejected, it shows the active-low interrupt input instead of data. That lets the host poll the interrupt state without running a transaction. The block enforces a minimum high time on select before it accepts a start. A select-low period with the wrong number of clock pulses is discarded and flagged. The host keeps the serial clock at no more than one sixteenth of the system clock and observes the three-cycle guard times around select.

A three-state machine controls the port. The states are IDLE (waiting), ACTIVE (transfer running) and BLOCKED (a rejected start is waiting for select to return high). The transitions are as follows:
- IDLE to ACTIVE on an accepted select fall.
- IDLE to BLOCKED on a select fall that comes too early.
- ACTIVE to IDLE on a select rise, which also ends the frame.
- BLOCKED to IDLE on a select rise.

Top module: `spi_intmux_slave`

## Requirements
- R1: While reset is asserted and directly after it, `rx_valid` and `frame_err` are 0, `rx_word` is 0 and `miso` equals `irq_n`.
- R2: While select is high and the port is not in a transfer, `miso` follows `irq_n` with no clock delay.
- R3: Bits on `mosi` are taken on rising serial clock edges, the first one as bit 31 and the last one as bit 0. When select rises after exactly 32 such edges, `rx_word` takes the word and `rx_valid` is 1 for exactly one cycle. This happens within 10 system clocks of the rise.
- R4: During a transfer, `miso` carries `tx_word` most significant bit first. Bit 31 is driven from the start until the first falling serial clock edge that follows a rising one. Each later falling edge advances one bit, and zeros follow after bit 0.
- R5: `tx_word` is sampled only at the accepted start. Changing it during a transfer does not change the bits on `miso`.
- R6: A frame with any bit count other than 32 (0, 8, 31, 33) produces a one-cycle `frame_err` pulse. In that case `rx_valid` stays 0 and `rx_word` keeps its previous value.
- R7: A select fall after fewer than 3 system clocks of sampled select high is ignored. Until select returns high, `miso` shows `irq_n`, and the following rise raises neither `rx_valid` nor `frame_err`.
- R8: Serial clock and data activity while select is high has no effect: no strobe, `miso` stays at `irq_n`, and the next transfer receives its word correctly.
- R9: `rx_valid` and `frame_err` are never high together, and neither stays high for two cycles in a row.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 16 times the serial clock rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n_pin | input | 1 | Serial select, active low, idles high |
| sck_pin | input | 1 | Serial clock, idles high |
| mosi_pin | input | 1 | Serial data from the host |
| miso | output | 1 | Serial data to the host; shows `irq_n` when not transferring |
| tx_word | input | 32 | Word to send, loaded at an accepted start |
| rx_word | output | 32 | Last complete received word |
| rx_valid | output | 1 | One-cycle strobe when `rx_word` is updated |
| frame_err | output | 1 | One-cycle strobe when a frame had the wrong bit count |
| irq_n | input | 1 | Active-low interrupt status shown on `miso` when idle |

## Verification
A table of transfers is run with different pairs of received and sent words, including all-ones, all-zeros, single-edge-bit patterns and mixed words. These separate bit order, stuck bits and shift-direction faults on both data paths. The same table also holds frames of 8, 31 and 33 pulses, which tell an exact-count check apart from an at-least or at-most check. Directed runs then cover clock activity with select high, a restart after only two high cycles, and toggling of the interrupt line, which shows whether `miso` is muxed by state or by pin.

// File: rtl/spi_intmux_pkg.sv
package spi_intmux_pkg;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_ACTIVE  = 2'd1,
        ST_BLOCKED = 2'd2
    } link_state_t;

endpackage

// File: rtl/spi_pin_sync.sv
module spi_pin_sync #(
    parameter int          WIDTH   = 3,
    parameter logic [WIDTH-1:0] RST_VAL = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] pin_i,
    output logic [WIDTH-1:0] lvl_o,
    output logic [WIDTH-1:0] rise_o,
    output logic [WIDTH-1:0] fall_o
);

    // Two flops per pin for metastability, a third to find edges.
    for (genvar g = 0; g < WIDTH; g++) begin : g_pin
        logic meta_q;
        logic stab_q;
        logic prev_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                meta_q <= RST_VAL[g];
                stab_q <= RST_VAL[g];
                prev_q <= RST_VAL[g];
            end else begin
                meta_q <= pin_i[g];
                stab_q <= meta_q;
                prev_q <= stab_q;
            end
        end

        assign lvl_o[g]  = stab_q;
        assign rise_o[g] = stab_q & ~prev_q;
        assign fall_o[g] = ~stab_q & prev_q;
    end

endmodule

// File: rtl/spi_tx_shifter.sv
module spi_tx_shifter #(
    parameter int WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [WORD_W-1:0] word_i,
    input  logic              shift_i,
    output logic              bit_o
);

    logic [WORD_W-1:0] sh_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q <= '0;
        end else if (load_i) begin
            sh_q <= word_i;
        end else if (shift_i) begin
            sh_q <= {sh_q[WORD_W-2:0], 1'b0};
        end
    end

    assign bit_o = sh_q[WORD_W-1];

endmodule

// File: rtl/spi_rx_shifter.sv
module spi_rx_shifter #(
    parameter int WORD_W = 32,
    localparam int CNT_W = $clog2(WORD_W + 2)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear_i,
    input  logic              take_i,
    input  logic              bit_i,
    output logic [WORD_W-1:0] word_o,
    output logic [CNT_W-1:0]  count_o
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [WORD_W-1:0] sh_q;
    logic [CNT_W-1:0]  cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q  <= '0;
            cnt_q <= '0;
        end else if (clear_i) begin
            sh_q  <= '0;
            cnt_q <= '0;
        end else if (take_i) begin
            sh_q <= {sh_q[WORD_W-2:0], bit_i};
            if (cnt_q != CNT_MAX) begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    assign word_o  = sh_q;
    assign count_o = cnt_q;

endmodule

// File: rtl/spi_intmux_slave.sv
module spi_intmux_slave
    import spi_intmux_pkg::*;
#(
    parameter int WORD_W    = 32,
    parameter int GUARD_CYC = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n_pin,
    input  logic              sck_pin,
    input  logic              mosi_pin,
    output logic              miso,
    input  logic [WORD_W-1:0] tx_word,
    output logic [WORD_W-1:0] rx_word,
    output logic              rx_valid,
    output logic              frame_err,
    input  logic              irq_n
);

    localparam int CNT_W   = $clog2(WORD_W + 2);
    localparam int GUARD_W = $clog2(GUARD_CYC + 1);
    localparam logic [GUARD_W-1:0] GUARD_MAX = GUARD_W'(GUARD_CYC);
    localparam logic [CNT_W-1:0]   FULL_CNT  = CNT_W'(WORD_W);

    // Pin index inside the synchronizer bundle.
    localparam int P_CS   = 2;
    localparam int P_SCK  = 1;
    localparam int P_MOSI = 0;

    logic [2:0] pin_lvl, pin_rise, pin_fall;

    spi_pin_sync #(
        .WIDTH   (3),
        .RST_VAL (3'b111)
    ) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin_i  ({cs_n_pin, sck_pin, mosi_pin}),
        .lvl_o  (pin_lvl),
        .rise_o (pin_rise),
        .fall_o (pin_fall)
    );

    logic cs_lvl, cs_rise, cs_fall, sck_rise, sck_fall, mosi_lvl;
    assign cs_lvl   = pin_lvl[P_CS];
    assign cs_rise  = pin_rise[P_CS];
    assign cs_fall  = pin_fall[P_CS];
    assign sck_rise = pin_rise[P_SCK];
    assign sck_fall = pin_fall[P_SCK];
    assign mosi_lvl = pin_lvl[P_MOSI];

    // Counts sampled select-high cycles, saturating at the guard time.
    logic [GUARD_W-1:0] guard_q;
    logic               guard_ok;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            guard_q <= '0;
        end else if (!cs_lvl) begin
            guard_q <= '0;
        end else if (guard_q != GUARD_MAX) begin
            guard_q <= guard_q + 1'b1;
        end
    end

    assign guard_ok = (guard_q == GUARD_MAX);

    // State register.
    link_state_t state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state logic.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (cs_fall) begin
                    state_d = guard_ok ? ST_ACTIVE : ST_BLOCKED;
                end
            end
            ST_ACTIVE: begin
                if (cs_rise) begin
                    state_d = ST_IDLE;
                end
            end
            ST_BLOCKED: begin
                if (cs_rise) begin
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Output and datapath control.
    logic [CNT_W-1:0]  bits_seen;
    logic [WORD_W-1:0] rx_shift_word;
    logic              tx_bit;
    logic              start_load, bit_take, bit_advance, frame_end, word_ok;
    logic              in_xfer;

    always_comb begin
        start_load  = 1'b0;
        bit_take    = 1'b0;
        bit_advance = 1'b0;
        frame_end   = 1'b0;
        in_xfer     = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                start_load = cs_fall && guard_ok;
            end
            ST_ACTIVE: begin
                in_xfer     = 1'b1;
                bit_take    = sck_rise;
                bit_advance = sck_fall && (bits_seen != '0);
                frame_end   = cs_rise;
            end
            ST_BLOCKED: begin
                in_xfer = 1'b0;
            end
            default: in_xfer = 1'b0;
        endcase
        word_ok = frame_end && (bits_seen == FULL_CNT);
    end

    spi_tx_shifter #(
        .WORD_W (WORD_W)
    ) u_tx (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (start_load),
        .word_i  (tx_word),
        .shift_i (bit_advance),
        .bit_o   (tx_bit)
    );

    spi_rx_shifter #(
        .WORD_W (WORD_W)
    ) u_rx (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (start_load),
        .take_i  (bit_take),
        .bit_i   (mosi_lvl),
        .word_o  (rx_shift_word),
        .count_o (bits_seen)
    );

    // Result registers and strobes.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_word   <= '0;
            rx_valid  <= 1'b0;
            frame_err <= 1'b0;
        end else begin
            rx_valid  <= word_ok;
            frame_err <= frame_end && !word_ok;
            if (word_ok) begin
                rx_word <= rx_shift_word;
            end
        end
    end

    assign miso = in_xfer ? tx_bit : irq_n;

endmodule

// File: rtl/spi_intmux_slave_chk.sv
module spi_intmux_slave_chk #(
    parameter int WORD_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cs_n_pin,
    input logic              irq_n,
    input logic              miso,
    input logic [WORD_W-1:0] rx_word,
    input logic              rx_valid,
    input logic              frame_err
);

    // R1: strobes are low while reset is held.
    always @(posedge clk) begin
        if (!rst_n) begin
            a_r1_reset_quiet: assert (!rx_valid && !frame_err);
        end
    end

    // R9
    a_r9_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(rx_valid && frame_err));

    // R9
    a_r9_valid_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid);

    // R9
    a_r9_err_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        frame_err |=> !frame_err);

    // R3: a completed word follows a select rise three samples back.
    a_r3_valid_after_rise: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> $past(cs_n_pin, 3));

    // R6
    a_r6_err_after_rise: assert property (@(posedge clk) disable iff (!rst_n)
        frame_err |-> $past(cs_n_pin, 3));

    // R6: the word only moves together with its strobe.
    a_r6_word_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_word != $past(rx_word)) |-> rx_valid);

    // R2: select held high long enough means miso carries the interrupt.
    a_r2_irq_shown: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n_pin && $past(cs_n_pin) && $past(cs_n_pin, 2) && $past(cs_n_pin, 3))
        |-> (miso == irq_n));

endmodule

bind spi_intmux_slave spi_intmux_slave_chk #(
    .WORD_W (WORD_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cs_n_pin  (cs_n_pin),
    .irq_n     (irq_n),
    .miso      (miso),
    .rx_word   (rx_word),
    .rx_valid  (rx_valid),
    .frame_err (frame_err)
);

// File: tb/sim_spi_intmux_slave.sv
module sim_spi_intmux_slave;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs_n = 1'b1;
    logic        sck = 1'b1;
    logic        mosi = 1'b1;
    logic        irq_n = 1'b1;
    logic [31:0] tx_word = '0;
    logic        miso;
    logic [31:0] rx_word;
    logic        rx_valid;
    logic        frame_err;

    int errors = 0;
    int checks = 0;
    int cyc = 0;

    always #2.5 clk = ~clk;

    spi_intmux_slave u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_n_pin  (cs_n),
        .sck_pin   (sck),
        .mosi_pin  (mosi),
        .miso      (miso),
        .tx_word   (tx_word),
        .rx_word   (rx_word),
        .rx_valid  (rx_valid),
        .frame_err (frame_err),
        .irq_n     (irq_n)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            errors = errors + 1;
            checks = checks + 1;
            $display("FAIL watchdog: run hung, actual=%0d expected<150000", cyc);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic check(input bit ok, input string tag, input logic [63:0] act,
                         input logic [63:0] exp);
        checks = checks + 1;
        if (!ok) begin
            errors = errors + 1;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Clocks n bits out of mo (MSB first), samples miso before each rise.
    task automatic clock_bits(input logic [31:0] mo, input int n, output logic [63:0] got);
        got = '0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            sck  = 1'b0;
            mosi = (i < 32) ? mo[31 - i] : 1'b0;
            wait_clk(7);
            got = {got[62:0], miso};
            sck = 1'b1;
            wait_clk(8);
        end
    endtask

    task automatic end_frame(output int nv, output int ne);
        wait_clk(6);
        cs_n = 1'b1;
        nv = 0;
        ne = 0;
        for (int k = 0; k < 10; k++) begin
            @(negedge clk);
            nv += int'(rx_valid);
            ne += int'(frame_err);
        end
    endtask

    typedef struct packed {
        logic [31:0] mo;
        logic [31:0] tx;
        logic [6:0]  nb;
    } vec_t;

    localparam vec_t VECS [7] = '{
        '{mo: 32'hA5A5F00F, tx: 32'h12345678, nb: 7'd32},
        '{mo: 32'hFFFFFFFF, tx: 32'h00000000, nb: 7'd32},
        '{mo: 32'h00000000, tx: 32'hFFFFFFFF, nb: 7'd32},
        '{mo: 32'h80000001, tx: 32'hDEADBEEF, nb: 7'd31},
        '{mo: 32'h13579BDF, tx: 32'hCAFEF00D, nb: 7'd33},
        '{mo: 32'h2468ACE0, tx: 32'h0F0F0F0F, nb: 7'd32},
        '{mo: 32'h5555AAAA, tx: 32'h89ABCDEF, nb: 7'd8}
    };

    initial begin
        logic [31:0] exp_rx;
        logic [63:0] got;
        int nv, ne;

        exp_rx = '0;

        // R1: reset state
        wait_clk(3);
        check(miso == irq_n, "R1 miso in reset", 64'(miso), 64'(irq_n));
        check(!rx_valid && !frame_err, "R1 strobes in reset",
              64'({rx_valid, frame_err}), 64'd0);
        check(rx_word == 32'd0, "R1 rx_word in reset", 64'(rx_word), 64'd0);
        rst_n = 1'b1;
        wait_clk(8);
        check(!rx_valid && !frame_err, "R1 strobes after reset",
              64'({rx_valid, frame_err}), 64'd0);

        // R2: miso follows irq_n at once when idle
        irq_n = 1'b0;
        #1;
        check(miso == 1'b0, "R2 irq low", 64'(miso), 64'd0);
        irq_n = 1'b1;
        #1;
        check(miso == 1'b1, "R2 irq high", 64'(miso), 64'd1);

        // R8: clock activity with select high
        irq_n = 1'b0;
        nv = 0;
        ne = 0;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            sck  = 1'b0;
            mosi = i[0];
            wait_clk(7);
            if (miso != irq_n) ne++;
            nv += int'(rx_valid) + int'(frame_err);
            sck = 1'b1;
            wait_clk(8);
            nv += int'(rx_valid) + int'(frame_err);
        end
        check(ne == 0, "R8 miso kept irq with select high", 64'(ne), 64'd0);
        check(nv == 0, "R8 no strobe from idle clocking", 64'(nv), 64'd0);
        irq_n = 1'b1;
        wait_clk(4);

        // Table of transfers: R3 R4 R5 R6
        foreach (VECS[v]) begin
            int n, k;
            logic [63:0] m, exp_bits, got_bits;
            n = int'(VECS[v].nb);
            k = (n > 32) ? 32 : n;
            tx_word = VECS[v].tx;
            cs_n = 1'b0;
            wait_clk(6);
            tx_word = ~VECS[v].tx;  // R5: late change must not show
            clock_bits(VECS[v].mo, n, got);
            end_frame(nv, ne);
            m = (64'd1 << k) - 64'd1;
            exp_bits = (64'(VECS[v].tx) >> (32 - k)) & m;
            got_bits = (got >> (n - k)) & m;
            check(got_bits == exp_bits, "R4 R5 miso bit stream", got_bits, exp_bits);
            if (n == 32) begin
                exp_rx = VECS[v].mo;
                check(nv == 1 && ne == 0, "R3 one valid strobe",
                      64'({nv[15:0], ne[15:0]}), 64'h10000);
            end else begin
                check(nv == 0 && ne == 1, "R6 one error strobe",
                      64'({nv[15:0], ne[15:0]}), 64'h1);
            end
            check(rx_word == exp_rx, "R3 R6 rx_word", 64'(rx_word), 64'(exp_rx));
            wait_clk(4);
        end

        // R7: restart after only two high cycles is rejected
        tx_word = 32'hFFFFFFFF;
        cs_n = 1'b0;
        wait_clk(6);
        cs_n = 1'b1;
        nv = 0;
        ne = 0;
        @(negedge clk);
        @(negedge clk);
        cs_n = 1'b0;
        irq_n = 1'b0;
        for (int k = 0; k < 8; k++) begin
            @(negedge clk);
            nv += int'(rx_valid);
            ne += int'(frame_err);
        end
        check(nv == 0 && ne == 1, "R6 empty frame flagged",
              64'({nv[15:0], ne[15:0]}), 64'h1);
        clock_bits(32'h0F0F1234, 32, got);
        check(got[31:0] == 32'h0, "R7 miso shows irq while rejected",
              got[31:0], 64'h0);
        end_frame(nv, ne);
        check(nv == 0 && ne == 0, "R7 no strobe after rejected frame",
              64'({nv[15:0], ne[15:0]}), 64'h0);
        check(rx_word == exp_rx, "R7 rx_word unchanged", 64'(rx_word), 64'(exp_rx));
        irq_n = 1'b1;
        wait_clk(6);

        // R7 R8: a clean transfer afterwards still works
        tx_word = 32'h600DCAFE;
        cs_n = 1'b0;
        wait_clk(6);
        clock_bits(32'hC001D00D, 32, got);
        end_frame(nv, ne);
        check(got[31:0] == 32'h600DCAFE, "R4 miso after recovery",
              got[31:0], 64'h600DCAFE);
        check(rx_word == 32'hC001D00D && nv == 1, "R3 word after recovery",
              64'(rx_word), 64'hC001D00D);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule